// File: doc/BRIEF.md
# Motor bridge fault supervisor

A synchronous fault manager for a three-phase half-bridge gate driver. It collects comparator flags from the analog front end and decides when the bridge may switch. It produces an active-low fault report, a request that puts all six switches in Hi-Z, and a separate disable for each phase's high-side switch. The flags are low-side overcurrent, shunt-voltage current limit, gate-supply undervoltage, per-phase bootstrap undervoltage, and low-side and high-side overtemperature. Every flag and the enable pin pass through a two-flop synchronizer before any logic uses them.

Each fault class has its own way of recovering. Low-side overcurrent and high-side overtemperature are latched. A latch clears only on a low pulse on the enable pin whose width lies inside a window, or on a power-good reset. The current limit releases the bridge after the flag has stayed quiet for a set number of cycles. Gate-supply undervoltage and low-side overtemperature recover as soon as their flag drops. A bootstrap undervoltage turns off only the high-side switch of its own phase and is not reported. While enable is low, the bridge is held in Hi-Z whatever the fault state.

The pulse window comes from the clock frequency and the minimum and maximum pulse widths in nanoseconds (20 µs and 40 µs by default). The current-limit quiet time is a cycle-count parameter.

Top module: `bridge_fault_supervisor`

## Requirements
- R1: Once reset is released and the enable pin is high, a low-side overcurrent flag drives `fault_n` low and `bridge_hiz` high within 4 cycles. Both stay that way after the flag drops, because the fault is latched.
- R2: A latched fault clears only in two ways. One is a power-good reset (`rst_n` low). The other is a low pulse on `en` lasting from CLR_MIN to CLR_MAX clock cycles, both limits included. A low pulse of CLR_MIN-1 or CLR_MAX+1 cycles leaves the latch set.
- R3: If a latched fault's flag is still high when a valid clear pulse ends, the fault stays reported.
- R4: A current-limit flag drives `fault_n` low and `bridge_hiz` high. After the flag drops, both stay asserted for at least RETRY_CYC cycles and release within RETRY_CYC+4 cycles. If the flag returns during that wait, the wait starts over.
- R5: A gate-supply undervoltage flag drives `fault_n` low and `bridge_hiz` high. Both release within 4 cycles of the flag dropping.
- R6: A bootstrap undervoltage flag `boot_uv[x]` sets `hs_off[x]` within 4 cycles and leaves the other bits of `hs_off`, `fault_n` and `bridge_hiz` unchanged. It clears within 4 cycles of the flag dropping.
- R7: A low-side overtemperature flag drives `fault_n` low and `bridge_hiz` high, and recovers automatically within 4 cycles of the flag dropping.
- R8: A high-side overtemperature flag drives `fault_n` low and `bridge_hiz` high, is latched, and clears the same way as R2.
- R9: While `en` is low, `bridge_hiz` is high. `fault_n` then reflects only the active faults.
- R10: While `rst_n` is low, `fault_n` is 1, `bridge_hiz` is 1 and `hs_off` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-good, active-low asynchronous reset |
| en | input | 1 | Enable pin; a low pulse of valid width clears latched faults |
| ocp | input | 1 | Low-side overcurrent flag |
| ilim | input | 1 | Shunt-voltage current-limit flag |
| gvdd_uv | input | 1 | Gate-supply undervoltage flag |
| boot_uv | input | 3 | Per-phase bootstrap undervoltage flags |
| ot_ls | input | 1 | Low-side overtemperature flag |
| ot_hs | input | 1 | High-side overtemperature flag |
| fault_n | output | 1 | Fault report, active low |
| bridge_hiz | output | 1 | Request to place all three phases in Hi-Z |
| hs_off | output | 3 | Per-phase high-side switch disable |

## Verification
The hardest cases to reach are the edges of the clear-pulse window. Only a low time of exactly CLR_MIN or CLR_MAX cycles may clear a latch, and one cycle more or less must not. The bench drives the enable pin on falling clock edges for an exact cycle count, so the width after the synchronizer is known. It tries all four boundary widths against a set latch. It also repeats a valid pulse while the overcurrent flag is still high, and raises the current-limit flag again in the middle of a retry wait.

// File: rtl/bridge_fault_supervisor.sv
module bridge_fault_supervisor #(
  parameter int CLK_HZ     = 125_000_000,
  parameter int CLR_MIN_NS = 20_000,
  parameter int CLR_MAX_NS = 40_000,
  parameter int RETRY_CYC  = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       ocp,
  input  logic       ilim,
  input  logic       gvdd_uv,
  input  logic [2:0] boot_uv,
  input  logic       ot_ls,
  input  logic       ot_hs,
  output logic       fault_n,
  output logic       bridge_hiz,
  output logic [2:0] hs_off
);
  localparam int CLR_MIN = int'((longint'(CLK_HZ) * CLR_MIN_NS) / 64'd1_000_000_000);
  localparam int CLR_MAX = int'((longint'(CLK_HZ) * CLR_MAX_NS) / 64'd1_000_000_000);
  localparam int CW      = $clog2(CLR_MAX + 2);
  localparam int RW      = $clog2(RETRY_CYC + 1);

  logic [7:0] raw, s1, s2;
  logic       en1, en_s;
  logic       ocp_s, ilim_s, gvdd_s, ot_ls_s, ot_hs_s;
  logic [2:0] boot_s;
  logic [CW-1:0] lo_cnt;
  logic [RW-1:0] rcnt;
  logic       clr, lat_ocp, lat_hot, ilim_hold;

  assign raw = {ot_hs, ot_ls, boot_uv, gvdd_uv, ilim, ocp};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; en1 <= 1'b0; en_s <= 1'b0;
    end else begin
      s1 <= raw; s2 <= s1; en1 <= en; en_s <= en1;
    end

  assign ocp_s   = s2[0];
  assign ilim_s  = s2[1];
  assign gvdd_s  = s2[2];
  assign boot_s  = s2[5:3];
  assign ot_ls_s = s2[6];
  assign ot_hs_s = s2[7];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       lo_cnt <= CW'(CLR_MAX + 1);
    else if (en_s)                    lo_cnt <= '0;
    else if (lo_cnt <= CW'(CLR_MAX))  lo_cnt <= lo_cnt + 1'b1;

  assign clr = en_s && lo_cnt >= CW'(CLR_MIN) && lo_cnt <= CW'(CLR_MAX);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lat_ocp <= 1'b0; lat_hot <= 1'b0;
    end else begin
      lat_ocp <= ocp_s   | (lat_ocp & ~clr);
      lat_hot <= ot_hs_s | (lat_hot & ~clr);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ilim_hold <= 1'b0; rcnt <= '0;
    end else if (ilim_s) begin
      ilim_hold <= 1'b1; rcnt <= '0;
    end else if (ilim_hold) begin
      if (rcnt == RW'(RETRY_CYC - 1)) ilim_hold <= 1'b0;
      else                            rcnt <= rcnt + 1'b1;
    end

  assign fault_n    = ~(lat_ocp | lat_hot | ilim_hold | gvdd_s | ot_ls_s);
  assign bridge_hiz = ~fault_n | ~en_s;
  assign hs_off     = boot_s;
endmodule

// File: rtl/bridge_fault_supervisor_chk.sv
module bridge_fault_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic fault_n,
  input logic bridge_hiz,
  input logic lat_ocp,
  input logic lat_hot,
  input logic clr,
  input logic ilim_s,
  input logic gvdd_s,
  input logic ot_ls_s
);
  AST_FAULT_FORCES_HIZ: assert property (@(posedge clk) disable iff (!rst_n) !fault_n |-> bridge_hiz); // R1
  AST_OCP_LATCH_HOLDS:  assert property (@(posedge clk) disable iff (!rst_n) (lat_ocp && !clr) |=> !fault_n); // R2
  AST_HOT_LATCH_HOLDS:  assert property (@(posedge clk) disable iff (!rst_n) (lat_hot && !clr) |=> !fault_n); // R8
  AST_ILIM_REPORTED:    assert property (@(posedge clk) disable iff (!rst_n) ilim_s |=> !fault_n); // R4
  AST_GVDD_REPORTED:    assert property (@(posedge clk) disable iff (!rst_n) gvdd_s |-> !fault_n); // R5
  AST_OTLS_REPORTED:    assert property (@(posedge clk) disable iff (!rst_n) ot_ls_s |-> bridge_hiz); // R7
endmodule

bind bridge_fault_supervisor bridge_fault_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fault_n(fault_n), .bridge_hiz(bridge_hiz),
  .lat_ocp(lat_ocp), .lat_hot(lat_hot), .clr(clr), .ilim_s(ilim_s),
  .gvdd_s(gvdd_s), .ot_ls_s(ot_ls_s)
);

// File: tb/bridge_fault_supervisor_tb.sv
`timescale 1ns/1ps
module bridge_fault_supervisor_tb;
  localparam int HZ    = 2_000_000;
  localparam int CMIN  = 40;
  localparam int CMAX  = 80;
  localparam int RETRY = 50;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic ocp = 0, ilim = 0, gvdd_uv = 0, ot_ls = 0, ot_hs = 0;
  logic [2:0] boot_uv = '0;
  logic fault_n, bridge_hiz;
  logic [2:0] hs_off;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bridge_fault_supervisor #(.CLK_HZ(HZ), .CLR_MIN_NS(20_000), .CLR_MAX_NS(40_000), .RETRY_CYC(RETRY)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .ocp(ocp), .ilim(ilim), .gvdd_uv(gvdd_uv),
    .boot_uv(boot_uv), .ot_ls(ot_ls), .ot_hs(ot_hs),
    .fault_n(fault_n), .bridge_hiz(bridge_hiz), .hs_off(hs_off));

  function automatic logic exp_fault_n(logic g, logic t);
    return !(g | t);
  endfunction
  function automatic logic exp_hiz(logic fn, logic e);
    return !fn | !e;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic en_pulse(int n);
    en = 1'b0; cyc(n); en = 1'b1; cyc(6);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    cyc(3);
    chk("R10 fault_n", fault_n, 1); chk("R10 hiz", bridge_hiz, 1); chk("R10 hs_off", hs_off, 0);
    rst_n = 1'b1; en = 1'b1; cyc(4);
    chk("R9 hiz released", bridge_hiz, 0);

    // R1 overcurrent latch
    ocp = 1; cyc(4);
    chk("R1 fault_n", fault_n, 0); chk("R1 hiz", bridge_hiz, 1);
    ocp = 0; cyc(10);
    chk("R1 latched", fault_n, 0);
    // R2 window boundaries
    en_pulse(CMIN - 1); chk("R2 short pulse ignored", fault_n, 0);
    en_pulse(CMAX + 1); chk("R2 long pulse ignored", fault_n, 0);
    en_pulse(CMIN);     chk("R2 min pulse clears", fault_n, 1);
    ocp = 1; cyc(4); ocp = 0; cyc(4);
    en_pulse(CMAX);     chk("R2 max pulse clears", fault_n, 1);
    chk("R2 hiz after clear", bridge_hiz, 0);
    ocp = 1; cyc(4); ocp = 0; cyc(4);
    rst_n = 0; cyc(2); chk("R2 reset clears", fault_n, 1); rst_n = 1; cyc(4);
    // R3 re-set while present
    ocp = 1; cyc(4);
    en_pulse(CMIN + 5); chk("R3 still present", fault_n, 0);
    ocp = 0; cyc(4); chk("R3 latched after", fault_n, 0);
    en_pulse(CMIN + 5); chk("R3 cleared once gone", fault_n, 1);
    // R8 high-side overtemperature latched
    ot_hs = 1; cyc(4); chk("R8 fault_n", fault_n, 0); chk("R8 hiz", bridge_hiz, 1);
    ot_hs = 0; cyc(10); chk("R8 latched", fault_n, 0);
    en_pulse(CMIN - 1); chk("R8 short pulse ignored", fault_n, 0);
    en_pulse(CMIN + 1); chk("R8 cleared", fault_n, 1);
    // R4 retry timing
    ilim = 1; cyc(4); chk("R4 fault_n", fault_n, 0); chk("R4 hiz", bridge_hiz, 1);
    ilim = 0; cyc(RETRY); chk("R4 held through wait", fault_n, 0);
    cyc(4); chk("R4 released", fault_n, 1);
    ilim = 1; cyc(4); ilim = 0; cyc(RETRY / 2);
    ilim = 1; cyc(3); ilim = 0; cyc(RETRY);
    chk("R4 wait restarted", fault_n, 0);
    cyc(4); chk("R4 released after restart", fault_n, 1);
    // R5, R7 directed
    gvdd_uv = 1; cyc(4); chk("R5 fault_n", fault_n, 0); chk("R5 hiz", bridge_hiz, 1);
    gvdd_uv = 0; cyc(4); chk("R5 recovered", fault_n, 1);
    ot_ls = 1; cyc(4); chk("R7 fault_n", fault_n, 0); chk("R7 hiz", bridge_hiz, 1);
    ot_ls = 0; cyc(4); chk("R7 recovered", fault_n, 1);
    // R6 bootstrap per phase
    for (int p = 0; p < 3; p++) begin
      boot_uv = 3'b1 << p; cyc(4);
      chk("R6 hs_off", hs_off, 3'b1 << p); chk("R6 no report", fault_n, 1); chk("R6 no hiz", bridge_hiz, 0);
      boot_uv = 0; cyc(4); chk("R6 recovered", hs_off, 0);
    end
    // R9 enable low
    en = 0; cyc(4); chk("R9 hiz", bridge_hiz, 1); chk("R9 fault_n", fault_n, 1);
    en = 1; cyc(4);
    // random mix of automatic faults (R5 R6 R7 R9)
    for (int i = 0; i < 60; i++) begin
      logic g, t, e;
      logic [2:0] b;
      g = ($urandom % 4) == 0; t = ($urandom % 4) == 0;
      e = ($urandom % 5) != 0; b = 3'($urandom);
      gvdd_uv = g; ot_ls = t; boot_uv = b; en = e;
      cyc(4);
      chk("R5/R7 random fault_n", fault_n, exp_fault_n(g, t));
      chk("R9 random hiz", bridge_hiz, exp_hiz(exp_fault_n(g, t), e));
      chk("R6 random hs_off", hs_off, b);
      en = 1; cyc(2);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule